// File: doc/BRIEF.md
# Prototype-Matching Neuron Cell

This block is one neuron of a distance-based classifier. It holds a reference
vector of up to 256 byte-wide components, a 16-bit category word, a 7-bit
context tag and an influence-field threshold. A controller broadcasts an input
vector one component per strobe. The cell compares each component with the
stored byte at its running component index and folds the difference into a
16-bit distance. The fold is either a saturating sum of absolute differences
or a running maximum, chosen per strobe by a norm select.

An uncommitted cell in learn mode records the broadcast components as its
prototype. Writing a category in learn mode commits it and captures the
current global context. After that, in either mode, the cell reports its
distance to each new vector. It reports a hit when that distance is strictly
below its influence field. A forget strobe returns the cell to the idle,
uncommitted state.

Top module: `neuron_cell`

## Requirements
- R1: The component index starts at 0. Each plain component strobe (`comp_wr` without `last_wr`) adds one to it, and it holds at 255 once it reaches 255. A last-component strobe (`last_wr`, which also carries a component) sets it to 0.
- R2: A component strobe taken at index 0 discards the previous distance and starts the new one from that component's difference alone.
- R3: With `norm_sel`=0 the distance is the sum of absolute differences between input and stored components. The sum saturates at 0xFFFF.
- R4: With `norm_sel`=1 the distance is the largest absolute difference seen so far in the vector.
- R5: While `learn`=1 and the cell is uncommitted, each strobe stores `comp_val` at the current index. A committed cell's prototype is never changed by strobes.
- R6: A `cat_wr` with `learn`=1 and `cat_val[14:0]` not equal to 0x7FFF commits the cell. It stores the whole 16-bit word, whose bit 15 is the degenerated flag, and captures `glb_ctx`. A `cat_wr` with `learn`=0, or with bits 14:0 equal to 0x7FFF, has no effect.
- R7: A committed cell with a matching context sets `fire` exactly when its distance is strictly less than its influence field.
- R8: Contexts match when the stored and global contexts are equal, or when either of them is 0. A committed cell without a match reports distance 0xFFFF and `fire`=0.
- R9: An uncommitted cell reports distance 0xFFFF, category 0 and `fire`=0.
- R10: `forget` clears the category and the committed state. It takes priority over a `cat_wr` in the same cycle.
- R11: `aif_wr` loads `aif_val` into the influence field at any time. Reset gives the influence field the value AIF_RESET (0x4000).
- R12: After reset, `committed`=0, `comp_idx`=0, `cat_out`=0, `dist_out`=0xFFFF and `fire`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| comp_wr | input | 1 | Component strobe |
| last_wr | input | 1 | Last-component strobe, also carries a component |
| comp_val | input | 8 | Broadcast component value |
| norm_sel | input | 1 | 0: sum of differences, 1: maximum difference |
| learn | input | 1 | Learn mode |
| glb_ctx | input | 7 | Global context |
| cat_wr | input | 1 | Category write strobe |
| cat_val | input | 16 | Category word; bit 15 is the degenerated flag |
| aif_wr | input | 1 | Influence-field write strobe |
| aif_val | input | 16 | Influence-field value |
| forget | input | 1 | Return the cell to idle |
| comp_idx | output | 8 | Current component index |
| committed | output | 1 | Cell holds a prototype |
| cat_out | output | 16 | Stored category word, 0 when idle |
| dist_out | output | 16 | Distance, 0xFFFF when not taking part |
| fire | output | 1 | Distance below influence field |

## Verification
The bench forces the sum norm past 0xFFFF with a 300-component vector against an all-zero prototype. A design that wrapped the sum would report a small distance there, and a design that let the index wrap past 255 would restart the sum part-way through. It sets the influence field equal to the measured distance and then one above it, which exposes a non-strict compare. It replays the prototype after trying to relearn a committed cell, so a design that overwrote the prototype shows a non-zero distance. It also tries a reserved category, a context mismatch, the zero wildcard context, and a forget issued together with a category write. Random vectors mixed across both norms and several lengths catch a distance that is not restarted at index 0.

// File: rtl/neuron_cell.sv
module neuron_cell #(
  parameter int COMP_W    = 8,
  parameter int DEPTH     = 256,
  parameter int DIST_W    = 16,
  parameter int CAT_W     = 16,
  parameter int CTX_W     = 7,
  parameter logic [DIST_W-1:0] AIF_RESET = 16'h4000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     comp_wr,
  input  logic                     last_wr,
  input  logic [COMP_W-1:0]        comp_val,
  input  logic                     norm_sel,
  input  logic                     learn,
  input  logic [CTX_W-1:0]         glb_ctx,
  input  logic                     cat_wr,
  input  logic [CAT_W-1:0]         cat_val,
  input  logic                     aif_wr,
  input  logic [DIST_W-1:0]        aif_val,
  input  logic                     forget,
  output logic [$clog2(DEPTH)-1:0] comp_idx,
  output logic                     committed,
  output logic [CAT_W-1:0]         cat_out,
  output logic [DIST_W-1:0]        dist_out,
  output logic                     fire
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DEPTH - 1);
  localparam logic [DIST_W-1:0] DIST_MAX = '1;
  localparam logic [CAT_W-2:0] CAT_BAD = '1;

  logic [COMP_W-1:0] proto [DEPTH];
  logic [IDX_W-1:0]  idx_q;
  logic [DIST_W-1:0] acc_q, aif_q;
  logic [CAT_W-1:0]  cat_q;
  logic [CTX_W-1:0]  ctx_q;
  logic              comm_q;

  logic              strobe;
  logic [COMP_W-1:0] diff;
  logic [DIST_W-1:0] base;
  logic [DIST_W:0]   sum;
  logic [DIST_W-1:0] acc_nx;
  logic              ctx_ok, cat_take;

  assign strobe   = comp_wr | last_wr;
  assign diff     = (comp_val >= proto[idx_q]) ? comp_val - proto[idx_q]
                                               : proto[idx_q] - comp_val;
  assign base     = (idx_q == '0) ? '0 : acc_q;
  assign sum      = {1'b0, base} + {{(DIST_W+1-COMP_W){1'b0}}, diff};
  assign acc_nx   = norm_sel ? ((DIST_W'(diff) > base) ? DIST_W'(diff) : base)
                             : (sum[DIST_W] ? DIST_MAX : sum[DIST_W-1:0]);
  assign ctx_ok   = (ctx_q == glb_ctx) || (ctx_q == '0) || (glb_ctx == '0);
  assign cat_take = cat_wr && learn && (cat_val[CAT_W-2:0] != CAT_BAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (strobe) begin
      acc_q <= acc_nx;
      if (last_wr)             idx_q <= '0;
      else if (idx_q != IDX_TOP) idx_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) proto[i] <= '0;
    end else if (strobe && learn && !comm_q) begin
      proto[idx_q] <= comp_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      comm_q <= 1'b0;
      cat_q  <= '0;
      ctx_q  <= '0;
    end else if (forget) begin
      comm_q <= 1'b0;
      cat_q  <= '0;
    end else if (cat_take) begin
      comm_q <= 1'b1;
      cat_q  <= cat_val;
      ctx_q  <= glb_ctx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      aif_q <= AIF_RESET;
    else if (aif_wr) aif_q <= aif_val;
  end

  assign comp_idx  = idx_q;
  assign committed = comm_q;
  assign cat_out   = comm_q ? cat_q : '0;
  assign dist_out  = (comm_q && ctx_ok) ? acc_q : DIST_MAX;
  assign fire      = comm_q && ctx_ok && (acc_q < aif_q);

  // R1
  last_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_wr |=> comp_idx == '0);

  // R1
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_wr && !last_wr && comp_idx != IDX_TOP) |=> comp_idx == $past(comp_idx) + 1'b1);

  // R3
  sum_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !norm_sel && idx_q != '0) |=> acc_q >= $past(acc_q));

  // R4
  max_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && norm_sel && idx_q != '0) |=> acc_q >= $past(acc_q));

  // R10
  forget_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    forget |=> (!committed && cat_out == '0));

  // R6
  bad_cat_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cat_wr && !forget && (!learn || cat_val[CAT_W-2:0] == CAT_BAD)) |=> $stable(committed));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (forget && !aif_wr) |=> (!fire && dist_out == DIST_MAX));
endmodule

// File: tb/neuron_cell_tb.sv
module neuron_cell_tb;
  logic clk = 0, rst_n = 0;
  logic comp_wr = 0, last_wr = 0, norm_sel = 0, learn = 0;
  logic [7:0] comp_val = 0;
  logic [6:0] glb_ctx = 0;
  logic cat_wr = 0, aif_wr = 0, forget = 0;
  logic [15:0] cat_val = 0, aif_val = 0;
  logic [7:0] comp_idx;
  logic committed, fire;
  logic [15:0] cat_out, dist_out;

  int n_chk = 0, n_bad = 0;
  logic [7:0] proto [256];
  logic [7:0] vin [320];

  always #4 clk = ~clk;

  neuron_cell u_dut (.clk, .rst_n, .comp_wr, .last_wr, .comp_val, .norm_sel,
    .learn, .glb_ctx, .cat_wr, .cat_val, .aif_wr, .aif_val, .forget,
    .comp_idx, .committed, .cat_out, .dist_out, .fire);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    comp_wr = 0; last_wr = 0; cat_wr = 0; aif_wr = 0; forget = 0;
  endtask

  task automatic send_vec(int len, bit nrm);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      norm_sel = nrm; comp_val = vin[i];
      if (i == len - 1) last_wr = 1; else comp_wr = 1;
      tick();
    end
  endtask

  function automatic int exp_dist(int len, bit nrm);
    int acc = 0;
    for (int i = 0; i < len; i++) begin
      int k = (i > 255) ? 255 : i;
      int d = (vin[i] > proto[k]) ? vin[i] - proto[k] : proto[k] - vin[i];
      if (nrm) acc = (d > acc) ? d : acc;
      else begin acc = acc + d; if (acc > 65535) acc = 65535; end
    end
    return acc;
  endfunction

  task automatic put_cat(logic [15:0] v, bit f);
    @(negedge clk); cat_val = v; cat_wr = 1; forget = f; tick();
  endtask

  task automatic put_aif(logic [15:0] v);
    @(negedge clk); aif_val = v; aif_wr = 1; tick();
  endtask

  initial begin
    #1_200_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int len, d;
    bit nrm;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) proto[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    // R12
    check("R12 committed", committed, 0);
    check("R12 idx", comp_idx, 0);
    check("R12 cat", cat_out, 0);
    check("R12 dist", dist_out, 16'hFFFF);
    check("R12 fire", fire, 0);

    // R9 uncommitted reports idle values
    for (int i = 0; i < 8; i++) vin[i] = 8'($urandom);
    send_vec(8, 0);
    check("R9 dist idle", dist_out, 16'hFFFF);
    check("R9 fire idle", fire, 0);

    // R5 learn a prototype of 32 components; R1 index steps
    learn = 1; glb_ctx = 7'd5;
    for (int i = 0; i < 32; i++) begin vin[i] = 8'($urandom); proto[i] = vin[i]; end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); comp_val = vin[i]; comp_wr = 1; tick();
    end
    check("R1 idx step", comp_idx, 3);
    @(negedge clk); comp_val = vin[3]; last_wr = 1; tick();
    check("R1 idx after last", comp_idx, 0);
    send_vec(32, 0);
    check("R1 idx end", comp_idx, 0);
    // R6 reject reserved category and category written outside learn
    put_cat(16'h7FFF, 0);
    check("R6 reserved cat", committed, 0);
    learn = 0; put_cat(16'h0012, 0);
    check("R6 cat in recognise", committed, 0);
    learn = 1;
    // R11 influence field
    put_aif(16'h0400);
    put_cat(16'h8012, 0);
    check("R6 commit", committed, 1);
    check("R6 degenerated word", cat_out, 16'h8012);
    learn = 0;

    // R2 R3 R4 R7 random recognition
    for (int t = 0; t < 40; t++) begin
      len = 1 + ($urandom % 32);
      nrm = 1'($urandom);
      for (int i = 0; i < len; i++)
        vin[i] = ($urandom % 2) ? 8'(proto[i] + ($urandom % 5)) : 8'($urandom);
      send_vec(len, nrm);
      d = exp_dist(len, nrm);
      check(nrm ? "R4 max dist" : "R3 sum dist", dist_out, d);
      check("R7 fire rand", fire, (d < 16'h0400) ? 1 : 0);
    end

    // R7 strict compare
    for (int i = 0; i < 32; i++) vin[i] = 8'(proto[i] ^ 8'h11);
    send_vec(32, 1);
    d = exp_dist(32, 1);
    check("R4 max 0x11", dist_out, d);
    put_aif(16'(d));
    check("R7 equal no fire", fire, 0);
    put_aif(16'(d + 1));
    check("R7 above fires", fire, 1);

    // R8 context
    glb_ctx = 7'd6; #1;
    check("R8 mismatch dist", dist_out, 16'hFFFF);
    check("R8 mismatch fire", fire, 0);
    glb_ctx = 7'd0; #1;
    check("R8 wildcard", dist_out, d);
    glb_ctx = 7'd5;

    // R5 committed prototype unchanged by learn-mode strobes
    learn = 1;
    for (int i = 0; i < 32; i++) vin[i] = 8'(~proto[i]);
    send_vec(32, 0);
    learn = 0;
    for (int i = 0; i < 32; i++) vin[i] = proto[i];
    send_vec(32, 0);
    check("R5 proto kept", dist_out, 0);
    check("R7 exact fires", fire, 1);

    // R10 forget beats cat_wr
    learn = 1;
    put_cat(16'h0033, 1);
    check("R10 forget committed", committed, 0);
    check("R10 forget cat", cat_out, 0);
    check("R9 dist after forget", dist_out, 16'hFFFF);

    // R1 R3 saturation and index hold: zero prototype, 300 x 0xFF
    for (int i = 0; i < 256; i++) begin vin[i] = 0; proto[i] = 0; end
    send_vec(256, 0);
    put_cat(16'h0001, 0);
    learn = 0;
    for (int i = 0; i < 300; i++) vin[i] = 8'hFF;
    for (int i = 0; i < 299; i++) begin
      @(negedge clk); comp_val = 8'hFF; norm_sel = 0; comp_wr = 1; tick();
    end
    check("R1 idx holds", comp_idx, 255);
    @(negedge clk); comp_val = 8'hFF; last_wr = 1; tick();
    check("R3 saturate", dist_out, exp_dist(300, 0));
    send_vec(300, 1);
    check("R4 max ff", dist_out, 16'h00FF);
    check("R2 restart", comp_idx, 0);
    vin[0] = 8'h03;
    send_vec(1, 0);
    check("R2 fresh dist", dist_out, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule